// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Register Bank

This block gathers fifteen level-sensitive interrupt sources (numbered 1 to 15) and spreads them over up to sixteen processors. Software reaches it through a simple 32-bit register port: one enable, one write strobe, a byte address and write data, with read data returned in the same cycle. Global registers hold a priority level per source, the shared pending set, a broadcast selection and a multiprocessor status word. Each processor has its own enable mask and its own force register. Every processor gets one interrupt request line, and it gets a reset pulse and a run pulse that restart it when it is halted.

A rising source is normally recorded in the shared pending set. When the part is configured with more than one processor and the source is marked for broadcast, it is instead placed in the force register of every processor that enables it. Source 15 is non-maskable in its delivery behaviour: each new delivery to a processor briefly drops that processor's request line so that the processor sees a fresh edge. Selecting the winning source and acknowledging it are done by a neighbouring block and are not part of this one.

Top module: `mpirq_regbank`

## Requirements
- R1: Word offsets (byte address, bits 1:0 ignored): 0x00 level, 0x04 pending, 0x08 global force, 0x0C clear, 0x10 status, 0x14 broadcast, 0x40+4n mask of processor n, 0x80+4n force of processor n, 0xC0+4n extended acknowledge of processor n. Source s sits at bit s of every source register; bit 0 and bits 31:16 read as zero. The level register keeps bits 15:1. Reads of the global force, clear, extended acknowledge, unmapped offsets and registers of processors n >= NCPU return zero, and writes to those processor slots change nothing.
- R2: Status bits 31:28 read NCPU-1 and bit 27 reads 1 only when NCPU > 1; after reset bits 26:0 read 0x0010001. The broadcast register is writable only when NCPU > 1, and reads zero otherwise.
- R3: A write to the clear register drops pending bit s only when data bit s is 1 and input s is low in that same cycle; a source whose input is high keeps its pending bit, even when it rises in the cycle of the clear write.
- R4: A rising edge on input s sets pending bit s at the next clock edge only when at least one processor's mask bit s is 1; with no processor enabling s, pending is unchanged.
- R5: When NCPU > 1 and broadcast bit s is 1, a rising edge on input s sets bit s in the force register of every processor whose mask bit s is 1 and leaves pending bit s unchanged.
- R6: A write to the force register of processor n ORs in those data bits 15:1 that are also set in that processor's mask; other bits are not set.
- R7: A write to the global force register ORs (data AND mask of processor 0) into pending only when NCPU = 1; with NCPU > 1 it has no effect.
- R8: A status write ORs data bits 26:0 into the status register; for each processor i whose status bit i was 0 and whose data bit i is 1, cpu_rst[i] and cpu_run[i] are high for exactly the one cycle after the write edge.
- R9: cpu_irq[n] is registered: one clock after the state holds (pending AND mask n) nonzero, or (NCPU > 1 and force n nonzero), it is high; otherwise it is low one clock later.
- R10: When source 15 is newly delivered to processor n (a rising input 15 with mask bit 15 of n set, or a force write to n with data bit 15 and mask bit 15 set), cpu_irq[n] is low in the cycle after that edge and follows R9 from the next edge on, even if it was high before.
- R11: Writes to the pending register and to extended acknowledge registers leave every register unchanged.
- R12: Reset (rst_n low) clears masks, force registers, pending, level, broadcast, the input history and all outputs, and restores status to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_in | input | 15 | Level inputs for sources 15..1 (bit s = source s) |
| cpu_irq | output | NCPU | Interrupt request per processor |
| cpu_rst | output | NCPU | One-cycle reset pulse per processor |
| cpu_run | output | NCPU | One-cycle run pulse per processor |

## Verification
The sharpest collision is a clear write landing in the same cycle that the same source's input rises: the clear must lose, because the input is already high when the write is sampled. The bench drives the input and the clear write on the same falling edge and reads pending back afterwards, expecting the bit to be set. A second collision puts a non-maskable delivery on a processor whose line is already high, and the bench samples the line in each of the two following cycles, expecting low and then high.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
  localparam int SRC_HI = 15;
  typedef logic [SRC_HI:1] src_t;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_MASK   = 2'd1,
    RG_FORCE  = 2'd2,
    RG_EXTACK = 2'd3
  } region_e;

  localparam logic [3:0] W_LEVEL  = 4'd0;
  localparam logic [3:0] W_PEND   = 4'd1;
  localparam logic [3:0] W_GFORCE = 4'd2;
  localparam logic [3:0] W_CLEAR  = 4'd3;
  localparam logic [3:0] W_STAT   = 4'd4;
  localparam logic [3:0] W_BCAST  = 4'd5;

  localparam logic [26:0] STAT_RST = 27'h0010001;
endpackage

// File: rtl/mpirq_src_edge.sv
module mpirq_src_edge
  import mpirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_t lvl_in,
  output src_t rise
);
  src_t lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_in;
  end

  assign rise = lvl_in & ~lvl_q;
endmodule

// File: rtl/mpirq_global.sv
module mpirq_global
  import mpirq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [3:0]      word,
  input  logic [31:0]     wdata,
  input  src_t            rise,
  input  src_t            lvl,
  input  src_t            mask_any,
  input  src_t            mask0,
  output src_t            level,
  output src_t            pending,
  output src_t            bcast,
  output src_t            bcast_route,
  output logic [26:0]     stat,
  output logic [NCPU-1:0] kick
);
  localparam bit BAV    = (NCPU > 1);
  localparam bit SINGLE = (NCPU == 1);

  src_t            level_d, pend_d, bcast_d, pend_set, pend_clr;
  logic [26:0]     stat_d;
  logic [NCPU-1:0] kick_d;

  assign bcast_route = BAV ? (rise & bcast) : '0;

  always_comb begin
    level_d  = level;
    bcast_d  = bcast;
    stat_d   = stat;
    kick_d   = '0;
    pend_set = rise & mask_any & ~bcast_route;
    pend_clr = '0;
    if (we) begin
      case (word)
        W_LEVEL:  level_d = wdata[SRC_HI:1];
        W_GFORCE: if (SINGLE) pend_set = pend_set | (wdata[SRC_HI:1] & mask0);
        W_CLEAR:  pend_clr = wdata[SRC_HI:1] & ~lvl;
        W_STAT: begin
          stat_d = stat | wdata[26:0];
          for (int c = 0; c < NCPU; c++) kick_d[c] = wdata[c] & ~stat[c];
        end
        W_BCAST:  if (BAV) bcast_d = wdata[SRC_HI:1];
        default:  ;
      endcase
    end
    pend_d = (pending & ~pend_clr) | pend_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      pending <= '0;
      bcast   <= '0;
      stat    <= STAT_RST;
      kick    <= '0;
    end else begin
      level   <= level_d;
      pending <= pend_d;
      bcast   <= bcast_d;
      stat    <= stat_d;
      kick    <= kick_d;
    end
  end
endmodule

// File: rtl/mpirq_cpu_slice.sv
module mpirq_cpu_slice
  import mpirq_pkg::*;
#(
  parameter bit BAV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_we,
  input  logic force_we,
  input  src_t wdata,
  input  src_t pending,
  input  src_t bcast_route,
  input  src_t rise,
  output src_t mask,
  output src_t frc,
  output logic irq
);
  src_t mask_d, frc_d, frc_set;
  logic nmi_hit, req, irq_d;

  always_comb begin
    mask_d  = mask_we ? wdata : mask;
    frc_set = bcast_route & mask;
    if (force_we) frc_set = frc_set | (wdata & mask);
    frc_d   = frc | frc_set;
    nmi_hit = mask[SRC_HI] & (rise[SRC_HI] | (force_we & wdata[SRC_HI]));
    req     = (|(pending & mask)) | (BAV & (|frc));
    irq_d   = req & ~nmi_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      frc  <= '0;
      irq  <= 1'b0;
    end else begin
      mask <= mask_d;
      frc  <= frc_d;
      irq  <= irq_d;
    end
  end
endmodule

// File: rtl/mpirq_regbank.sv
module mpirq_regbank
  import mpirq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [15:1]     irq_in,
  output logic [NCPU-1:0] cpu_irq,
  output logic [NCPU-1:0] cpu_rst,
  output logic [NCPU-1:0] cpu_run
);
  localparam bit         BAV    = (NCPU > 1);
  localparam logic [3:0] CNT_M1 = 4'(NCPU - 1);

  region_e         region;
  logic [3:0]      word;
  logic            wr_go, glb_we;
  logic [NCPU-1:0] mask_we, force_we, kick;
  src_t            src_rise, level_q, pending_q, bcast_q, bcast_route, mask_any;
  src_t            mask_a  [NCPU];
  src_t            force_a [NCPU];
  logic [26:0]     stat_q;
  logic            unused_bits;

  assign region      = region_e'(bus_addr[7:6]);
  assign word        = bus_addr[5:2];
  assign wr_go       = bus_en & bus_wr;
  assign glb_we      = wr_go & (region == RG_GLOBAL);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:27]};

  mpirq_src_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (irq_in),
    .rise   (src_rise)
  );

  always_comb begin
    mask_any = '0;
    for (int c = 0; c < NCPU; c++) mask_any = mask_any | mask_a[c];
  end

  mpirq_global #(.NCPU(NCPU)) u_global (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (glb_we),
    .word        (word),
    .wdata       (bus_wdata),
    .rise        (src_rise),
    .lvl         (irq_in),
    .mask_any    (mask_any),
    .mask0       (mask_a[0]),
    .level       (level_q),
    .pending     (pending_q),
    .bcast       (bcast_q),
    .bcast_route (bcast_route),
    .stat        (stat_q),
    .kick        (kick)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign mask_we[c]  = wr_go & (region == RG_MASK)  & (word == 4'(c));
    assign force_we[c] = wr_go & (region == RG_FORCE) & (word == 4'(c));

    mpirq_cpu_slice #(.BAV(BAV)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .mask_we     (mask_we[c]),
      .force_we    (force_we[c]),
      .wdata       (bus_wdata[SRC_HI:1]),
      .pending     (pending_q),
      .bcast_route (bcast_route),
      .rise        (src_rise),
      .mask        (mask_a[c]),
      .frc         (force_a[c]),
      .irq         (cpu_irq[c])
    );
  end

  assign cpu_rst = kick;
  assign cpu_run = kick;

  always_comb begin
    bus_rdata = '0;
    case (region)
      RG_GLOBAL: begin
        case (word)
          W_LEVEL: bus_rdata = {16'd0, level_q, 1'b0};
          W_PEND:  bus_rdata = {16'd0, pending_q, 1'b0};
          W_STAT:  bus_rdata = {CNT_M1, BAV, stat_q};
          W_BCAST: bus_rdata = {16'd0, bcast_q, 1'b0};
          default: bus_rdata = '0;
        endcase
      end
      RG_MASK: begin
        for (int c = 0; c < NCPU; c++)
          if (word == 4'(c)) bus_rdata = {16'd0, mask_a[c], 1'b0};
      end
      RG_FORCE: begin
        for (int c = 0; c < NCPU; c++)
          if (word == 4'(c)) bus_rdata = {16'd0, force_a[c], 1'b0};
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mpirq_regbank_chk.sv
module mpirq_regbank_chk
  import mpirq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_en,
  input logic            bus_wr,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [15:1]     irq_in,
  input logic [NCPU-1:0] cpu_irq,
  input logic [NCPU-1:0] cpu_rst,
  input src_t            pending,
  input src_t            rise,
  input src_t            mask0,
  input src_t            force0
);
  localparam bit BAV = (NCPU > 1);

  logic wr_clear, wr_pend, rd_stat;
  assign wr_clear = bus_en && bus_wr && (bus_addr[7:2] == 6'h03);
  assign wr_pend  = bus_en && bus_wr && (bus_addr[7:2] == 6'h01);
  assign rd_stat  = bus_en && !bus_wr && (bus_addr[7:2] == 6'h04);

  // R3: a high input protects its pending bit from a clear write
  p_clear_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> ((pending & $past(irq_in & pending)) == $past(irq_in & pending)));

  // R11: pending is not writable
  p_pend_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (rise == '0)) |=> $stable(pending));

  // R8: a restart pulse never lasts two cycles on the same processor
  p_kick_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_rst) |=> ((cpu_rst & $past(cpu_rst)) == '0));

  // R10: new source-15 delivery drops the line for one cycle
  p_nmi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[SRC_HI] && mask0[SRC_HI]) |=> !cpu_irq[0]);

  // R9: a raised line has a cause in the previous cycle
  p_req_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq[0] |-> $past((|(pending & mask0)) || (BAV && (|force0))));

  // R2: constant status fields
  p_stat_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata[31:27] == {4'(NCPU - 1), BAV}));
endmodule

bind mpirq_regbank mpirq_regbank_chk #(.NCPU(NCPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_in    (irq_in),
  .cpu_irq   (cpu_irq),
  .cpu_rst   (cpu_rst),
  .pending   (pending_q),
  .rise      (src_rise),
  .mask0     (mask_a[0]),
  .force0    (force_a[0])
);

// File: tb/mpirq_regbank_tb.sv
module mpirq_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en0 = 1'b0, en1 = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [15:1] irq_in = '0;
  logic [3:0]  irq0, rst0, run0;
  logic [0:0]  irq1, rst1, run1;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mpirq_regbank #(.NCPU(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(en0), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .irq_in(irq_in),
    .cpu_irq(irq0), .cpu_rst(rst0), .cpu_run(run0));

  mpirq_regbank #(.NCPU(1)) u_one (
    .clk(clk), .rst_n(rst_n), .bus_en(en1), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .irq_in(irq_in),
    .cpu_irq(irq1), .cpu_rst(rst1), .cpu_run(run1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; irq_in = '0;
    step(2); rst_n = 1'b1;
  endtask

  task automatic wrt(input bit one, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; en0 = !one; en1 = one;
    @(negedge clk); wr = 1'b0; en0 = 1'b0; en1 = 1'b0;
  endtask

  task automatic rd(input bit one, input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; wr = 1'b0; en0 = !one; en1 = one;
    #1 chk(tag, one ? rdata1 : rdata0, e);
    en0 = 1'b0; en1 = 1'b0;
  endtask

  task automatic src(input logic [15:1] v);
    @(negedge clk); irq_in = v;
  endtask

  initial begin
    step(2); rst_n = 1'b1;
    // R12 / R2 reset state
    rd(0, 8'h00, 32'h0, "R12 level reset");
    rd(0, 8'h04, 32'h0, "R12 pending reset");
    rd(0, 8'h10, 32'h38010001, "R2 status reset ncpu4");
    rd(1, 8'h10, 32'h00010001, "R2 status reset ncpu1");
    chk("R12 irq reset", {28'd0, irq0}, 32'h0);

    // R4 / R9 / R3 sweep over every source
    for (int s = 1; s <= 15; s++) begin
      logic [31:0] b;
      int c;
      b = 32'd1 << s;
      c = s % 4;
      src(b[15:1]); step(1);
      rd(0, 8'h04, 32'h0, "R4 rise with no mask");
      src('0);
      wrt(0, 8'(64 + 4 * c), b);
      src(b[15:1]);
      rd(0, 8'h04, b, "R4 rise sets pending");
      step(1);
      chk("R9 line follows pending and mask", {28'd0, irq0}, 32'd1 << c);
      src('0);
      wrt(0, 8'h0C, b);
      rd(0, 8'h04, 32'h0, "R3 clear with input low");
      wrt(0, 8'(64 + 4 * c), 32'h0);
      step(1);
      chk("R9 line low after unmask", {28'd0, irq0}, 32'h0);
    end

    // R3 clear versus high input, and collision with a rise
    do_reset();
    wrt(0, 8'h40, 32'h28);
    src(15'h0004);
    wrt(0, 8'h0C, 32'h08);
    rd(0, 8'h04, 32'h08, "R3 clear blocked by high input");
    src('0);
    wrt(0, 8'h0C, 32'h08);
    rd(0, 8'h04, 32'h0, "R3 clear after input low");
    @(negedge clk); irq_in = 15'h0010; addr = 8'h0C; wdata = 32'h20; wr = 1'b1; en0 = 1'b1;
    @(negedge clk); wr = 1'b0; en0 = 1'b0;
    rd(0, 8'h04, 32'h20, "R3 clear loses to same-cycle rise");
    chk("R9 line high with pending", {28'd0, irq0}, 32'h1);
    wrt(0, 8'h40, 32'h0);
    step(1);
    chk("R9 line drops when mask cleared", {28'd0, irq0}, 32'h0);
    wrt(0, 8'h40, 32'h20);
    step(1);
    chk("R9 line returns with mask", {28'd0, irq0}, 32'h1);
    // R11 read-only pending and extended ack
    wrt(0, 8'h04, 32'h0000FFFF);
    rd(0, 8'h04, 32'h20, "R11 pending write ignored");
    wrt(0, 8'hC4, 32'h0000FFFF);
    rd(0, 8'hC4, 32'h0, "R11 ext ack reads zero");

    // R5 broadcast routing, R6 masked force writes
    do_reset();
    wrt(0, 8'h14, 32'h40);
    rd(0, 8'h14, 32'h40, "R2 broadcast writable ncpu4");
    wrt(0, 8'h40, 32'h40);
    wrt(0, 8'h48, 32'h40);
    src(15'h0020);
    rd(0, 8'h04, 32'h0, "R5 broadcast bypasses pending");
    rd(0, 8'h80, 32'h40, "R5 force cpu0");
    rd(0, 8'h84, 32'h0, "R5 force cpu1 unmasked");
    rd(0, 8'h88, 32'h40, "R5 force cpu2");
    chk("R9 line from force", {28'd0, irq0}, 32'h5);
    wrt(0, 8'h44, 32'h00F1);
    wrt(0, 8'h84, 32'hFFFFFFFF);
    rd(0, 8'h84, 32'h00F0, "R6 force limited to mask and bits 15:1");
    rd(0, 8'h8C, 32'h0, "R6 force with empty mask");
    chk("R9 line cpu1 from force", {28'd0, irq0}, 32'h7);
    // R1 map edges
    wrt(0, 8'h54, 32'h0000FFFF);
    rd(0, 8'h54, 32'h0, "R1 unconfigured cpu mask");
    rd(0, 8'h18, 32'h0, "R1 unmapped offset");
    rd(0, 8'h08, 32'h0, "R1 global force reads zero");
    rd(0, 8'h0C, 32'h0, "R1 clear reads zero");
    wrt(0, 8'h00, 32'h0000FFFF);
    rd(0, 8'h00, 32'h0000FFFE, "R1 level bits 15:1");

    // R10 non-maskable source 15
    do_reset();
    wrt(0, 8'h40, 32'h8004);
    src(15'h0002); step(2);
    chk("R10 line high before nmi", {28'd0, irq0}, 32'h1);
    src(15'h4002); step(1);
    chk("R10 line dropped after nmi rise", {28'd0, irq0}, 32'h0);
    step(1);
    chk("R10 line back after one cycle", {28'd0, irq0}, 32'h1);
    wrt(0, 8'h80, 32'h8000);
    chk("R10 line dropped after nmi force", {28'd0, irq0}, 32'h0);
    step(1);
    chk("R10 line back after force", {28'd0, irq0}, 32'h1);
    rd(0, 8'h80, 32'h8000, "R6 nmi force bit stored");

    // R8 restart pulses
    do_reset();
    wrt(0, 8'h10, 32'h6);
    chk("R8 reset pulse", {28'd0, rst0}, 32'h6);
    chk("R8 run pulse", {28'd0, run0}, 32'h6);
    step(1);
    chk("R8 pulse one cycle", {28'd0, rst0}, 32'h0);
    rd(0, 8'h10, 32'h38010007, "R8 status sticky");
    wrt(0, 8'h10, 32'h7);
    chk("R8 no pulse when running", {28'd0, rst0}, 32'h0);
    wrt(0, 8'h10, 32'h00100008);
    chk("R8 pulse cpu3", {28'd0, run0}, 32'h8);
    rd(0, 8'h10, 32'h3811000F, "R8 status or of upper bits");

    // R7 global force
    wrt(0, 8'h40, 32'hFF);
    wrt(0, 8'h08, 32'hFF);
    rd(0, 8'h04, 32'h0, "R7 global force ignored ncpu4");
    wrt(1, 8'h40, 32'h30);
    wrt(1, 8'h08, 32'hFF);
    rd(1, 8'h04, 32'h30, "R7 global force single cpu");
    rd(1, 8'h08, 32'h0, "R7 global force reads zero");
    chk("R9 single cpu line", {31'd0, irq1}, 32'h1);
    wrt(1, 8'h14, 32'h40);
    rd(1, 8'h14, 32'h0, "R2 broadcast absent ncpu1");
    wrt(1, 8'h80, 32'h30);
    step(1);
    rd(1, 8'h80, 32'h30, "R6 force stored ncpu1");

    // R12 reset clears populated state
    do_reset();
    rd(0, 8'h40, 32'h0, "R12 mask cleared");
    rd(1, 8'h04, 32'h0, "R12 pending cleared");
    rd(1, 8'h80, 32'h0, "R12 force cleared");
    rd(0, 8'h10, 32'h38010001, "R12 status restored");
    chk("R12 lines low", {27'd0, irq1, irq0}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule